// File: doc/BRIEF.md
# Offset and Gain Correction Unit

This block turns raw filtered conversion results into calibrated 20-bit output codes. A calibration sequencer presents two reference readings on the raw input: first the zero-scale point, then the full-scale point, each marked by its own capture strobe. Once the full-scale point is taken, a sequential divider forms the reciprocal of the span (full minus zero) a single time. From then on every raw value is handled in a short pipeline: the zero point is subtracted, the difference is multiplied by the reciprocal, and the result is rounded to nearest and clamped.

A static range input selects straight-binary unipolar coding or offset-binary bipolar coding. In bipolar mode the zero-scale reading maps to midscale, and the code step covers twice as many raw units as in unipolar mode for the same span. A calibration-valid flag is low after reset, after either capture strobe, and after any change of the range input. While it is low, no output is marked valid, so a fresh calibration is needed before codes are trusted.

Top module: `calcorr_top`

## Requirements
- R1: After reset, cal_valid, code_valid and code are all 0.
- R2: A high cap_zero stores raw_data as the zero point Z and a high cap_full stores raw_data as the full point F; either strobe drops cal_valid on the next clock, and cal_valid rises no more than Q+4 clocks after the cap_full clock when F-Z is positive (Q = RAW_W+20).
- R3: When F-Z is zero or negative, cal_valid stays 0 and no code is produced.
- R4: While cal_valid is 0, raw_valid pulses give no code_valid.
- R5: A raw value sampled with raw_valid high and cal_valid high gives code_valid high exactly two clocks later, one code per input, including back-to-back inputs on consecutive clocks.
- R6: The calibration keeps K = floor(2^Q / (F-Z)); each conversion uses D = raw_data - Z.
- R7: With bipolar = 0, code = floor((D*K + 2^(Q-21)) / 2^(Q-20)), i.e. the span over 2^20 raw steps, rounded to nearest with halves going up; an input half a step above Z gives code 1.
- R8: With bipolar = 1, code = 80000h + floor((D*K + 2^(Q-20)) / 2^(Q-19)); Z gives 80000h, one step below gives 7FFFFh.
- R9: A result above FFFFFh is output as FFFFFh and a result below zero as 00000h, in both modes.
- R10: A change of bipolar drops cal_valid on the next clock and blocks codes until a new calibration completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_valid | input | 1 | raw_data holds a result to convert |
| raw_data | input | RAW_W | Raw filtered result, two's complement |
| cap_zero | input | 1 | Store raw_data as the zero-scale point |
| cap_full | input | 1 | Store raw_data as the full-scale point and start the reciprocal |
| bipolar | input | 1 | 0: unipolar straight binary, 1: bipolar offset binary |
| code_valid | output | 1 | code holds a new calibrated result |
| code | output | 20 | Calibrated, rounded and clamped output code |
| cal_valid | output | 1 | Stored calibration is usable |

## Verification
The assertions assume that the capture strobes are single-cycle pulses issued zero first, then full, and that bipolar is held steady across reset release; they say nothing about codes produced from a calibration whose points were swapped. The stimulus drives every input on the falling clock edge, issues strobes in that order with one clock between them, and changes the range input only when no conversion is being launched, then checks codes against a reference worked out from the stated formulas in wide integer arithmetic.

// File: rtl/calcorr_pkg.sv
// Shared constants and types for the offset and gain correction unit.
package calcorr_pkg;
    // Width of the calibrated output code.
    localparam int CODE_W = 20;

    // States of the span reciprocal divider.
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_t;
endpackage

// File: rtl/calcorr_store.sv
// Calibration point store.
// Holds the zero-scale and full-scale readings, launches the reciprocal
// divider one clock after a full-scale capture, and keeps the
// calibration-valid flag. Assumes strobes are single-cycle pulses.
module calcorr_store #(
    parameter int RAW_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [RAW_W-1:0] raw_data,
    input  logic                    cap_zero,
    input  logic                    cap_full,
    input  logic                    bipolar,
    input  logic                    div_done,
    input  logic                    div_ok,
    output logic signed [RAW_W-1:0] zero_pt,
    output logic signed [RAW_W:0]   span,
    output logic                    div_start,
    output logic                    div_abort,
    output logic                    mode_bip,
    output logic                    cal_ok
);
    logic signed [RAW_W-1:0] zero_q;
    logic signed [RAW_W-1:0] full_q;
    logic                    start_q;
    logic                    mode_q;
    logic                    ok_q;
    logic                    mode_flip;

    // Range input differs from the mode the calibration was made for.
    assign mode_flip = (bipolar != mode_q);
    // Any new capture or mode change cancels a reciprocal in progress.
    assign div_abort = cap_zero | cap_full | mode_flip;

    // Capture points, track mode, and maintain the calibration flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_q  <= '0;
            full_q  <= '0;
            start_q <= 1'b0;
            mode_q  <= bipolar;
            ok_q    <= 1'b0;
        end else begin
            if (cap_zero) zero_q <= raw_data;
            if (cap_full) full_q <= raw_data;
            start_q <= cap_full;
            mode_q  <= bipolar;
            if (div_abort)     ok_q <= 1'b0;
            else if (div_done) ok_q <= div_ok;
        end
    end

    assign zero_pt   = zero_q;
    assign span      = {full_q[RAW_W-1], full_q} - {zero_q[RAW_W-1], zero_q};
    assign div_start = start_q;
    assign mode_bip  = mode_q;
    assign cal_ok    = ok_q;
endmodule

// File: rtl/calcorr_recip.sv
// Span reciprocal divider.
// Restoring divider computing floor(2^Q / span), one quotient bit per
// clock, Q+1 clocks per run. A span of zero or below finishes at once
// with ok low. Abort returns it to idle; start in any state restarts it.
module calcorr_recip
    import calcorr_pkg::*;
#(
    parameter int SPAN_W = 25,
    parameter int Q      = 44
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     abort,
    input  logic signed [SPAN_W-1:0] span,
    output logic                     done,
    output logic                     ok,
    output logic [Q:0]               recip
);
    localparam int CNT_W = $clog2(Q + 2);

    div_state_t        state;
    logic [SPAN_W-1:0] divisor;
    logic [SPAN_W-1:0] rem;
    logic [CNT_W-1:0]  cnt;
    logic [Q:0]        quo;
    logic [SPAN_W:0]   trial;
    logic              fits;
    logic              span_bad;

    // Next partial remainder: dividend is a single 1 followed by Q zeros.
    always_comb begin
        trial    = {rem, (cnt == '0)};
        fits     = (trial >= {1'b0, divisor});
        span_bad = span[SPAN_W-1] || (span == '0);
    end

    // Step the divider one quotient bit per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= DIV_IDLE;
            divisor <= '0;
            rem     <= '0;
            cnt     <= '0;
            quo     <= '0;
            done    <= 1'b0;
            ok      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                state <= DIV_IDLE;
            end else if (start) begin
                if (span_bad) begin
                    state <= DIV_IDLE;
                    done  <= 1'b1;
                    ok    <= 1'b0;
                end else begin
                    state   <= DIV_RUN;
                    divisor <= span;
                    rem     <= '0;
                    cnt     <= '0;
                    quo     <= '0;
                end
            end else if (state == DIV_RUN) begin
                rem <= fits ? SPAN_W'(trial - {1'b0, divisor}) : trial[SPAN_W-1:0];
                quo <= {quo[Q-1:0], fits};
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(Q)) begin
                    state <= DIV_IDLE;
                    done  <= 1'b1;
                    ok    <= 1'b1;
                end
            end
        end
    end

    assign recip = quo;
endmodule

// File: rtl/calcorr_pipe.sv
// Conversion pipeline.
// Stage 1 subtracts the zero point; stage 2 multiplies by the span
// reciprocal, rounds to nearest (halves up), applies the mode scale and
// bias, and clamps to the code range. Both stages are gated by the
// calibration flag. Assumes recip is stable while the flag is high.
module calcorr_pipe
    import calcorr_pkg::*;
#(
    parameter int RAW_W = 24,
    parameter int Q     = 44
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    raw_valid,
    input  logic signed [RAW_W-1:0] raw_data,
    input  logic signed [RAW_W-1:0] zero_pt,
    input  logic [Q:0]              recip,
    input  logic                    mode_bip,
    input  logic                    cal_ok,
    output logic                    code_valid,
    output logic [CODE_W-1:0]       code
);
    localparam int PW   = RAW_W + Q + 3;
    localparam int SH_U = Q - CODE_W;
    localparam int SH_B = Q - CODE_W + 1;
    localparam logic signed [PW-1:0] HALF_U = PW'(1) << (SH_U - 1);
    localparam logic signed [PW-1:0] HALF_B = PW'(1) << (SH_B - 1);
    localparam logic signed [PW-1:0] BIAS   = PW'(1) << (CODE_W - 1);
    localparam logic signed [PW-1:0] MAXC   = (PW'(1) << CODE_W) - PW'(1);

    logic                    v1;
    logic signed [RAW_W:0]   d1;
    logic signed [PW-1:0]    d_ext;
    logic signed [PW-1:0]    r_ext;
    logic signed [PW-1:0]    prod;
    logic signed [PW-1:0]    sum_u;
    logic signed [PW-1:0]    sum_b;
    logic signed [PW-1:0]    scaled;
    logic [CODE_W-1:0]       sat;

    // Stage 1: offset removal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            d1 <= '0;
        end else begin
            v1 <= raw_valid & cal_ok;
            if (raw_valid & cal_ok)
                d1 <= {raw_data[RAW_W-1], raw_data} - {zero_pt[RAW_W-1], zero_pt};
        end
    end

    // Gain multiply, rounding, mode scaling and saturation.
    always_comb begin
        d_ext  = {{(PW-RAW_W-1){d1[RAW_W]}}, d1};
        r_ext  = {{(PW-Q-1){1'b0}}, recip};
        prod   = d_ext * r_ext;
        sum_u  = prod + HALF_U;
        sum_b  = prod + HALF_B;
        scaled = mode_bip ? ((sum_b >>> SH_B) + BIAS) : (sum_u >>> SH_U);
        if (scaled[PW-1])       sat = '0;
        else if (scaled > MAXC) sat = '1;
        else                    sat = scaled[CODE_W-1:0];
    end

    // Stage 2: register the finished code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_valid <= 1'b0;
            code       <= '0;
        end else begin
            code_valid <= v1 & cal_ok;
            if (v1 & cal_ok) code <= sat;
        end
    end
endmodule

// File: rtl/calcorr_top.sv
// Offset and gain correction unit, top level.
// Connects the calibration store, the span reciprocal divider and the
// conversion pipeline. Assumes the sequencer strobes the zero point
// before the full point and that the range input is static in use.
module calcorr_top
    import calcorr_pkg::*;
#(
    parameter int RAW_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    raw_valid,
    input  logic signed [RAW_W-1:0] raw_data,
    input  logic                    cap_zero,
    input  logic                    cap_full,
    input  logic                    bipolar,
    output logic                    code_valid,
    output logic [CODE_W-1:0]       code,
    output logic                    cal_valid
);
    localparam int Q      = RAW_W + CODE_W;
    localparam int SPAN_W = RAW_W + 1;

    logic signed [RAW_W-1:0]  zero_pt;
    logic signed [SPAN_W-1:0] span;
    logic                     div_start;
    logic                     div_abort;
    logic                     div_done;
    logic                     div_ok;
    logic [Q:0]               recip;
    logic                     mode_bip;
    logic                     cal_ok;

    calcorr_store #(.RAW_W(RAW_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_data  (raw_data),
        .cap_zero  (cap_zero),
        .cap_full  (cap_full),
        .bipolar   (bipolar),
        .div_done  (div_done),
        .div_ok    (div_ok),
        .zero_pt   (zero_pt),
        .span      (span),
        .div_start (div_start),
        .div_abort (div_abort),
        .mode_bip  (mode_bip),
        .cal_ok    (cal_ok)
    );

    calcorr_recip #(.SPAN_W(SPAN_W), .Q(Q)) u_recip (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .abort (div_abort),
        .span  (span),
        .done  (div_done),
        .ok    (div_ok),
        .recip (recip)
    );

    calcorr_pipe #(.RAW_W(RAW_W), .Q(Q)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_valid  (raw_valid),
        .raw_data   (raw_data),
        .zero_pt    (zero_pt),
        .recip      (recip),
        .mode_bip   (mode_bip),
        .cal_ok     (cal_ok),
        .code_valid (code_valid),
        .code       (code)
    );

    assign cal_valid = cal_ok;
endmodule

// File: rtl/calcorr_chk.sv
// Port-level temporal checks for the correction unit, bound to the top.
module calcorr_chk (
    input logic clk,
    input logic rst_n,
    input logic raw_valid,
    input logic cap_zero,
    input logic cap_full,
    input logic bipolar,
    input logic code_valid,
    input logic cal_valid
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!code_valid && !cal_valid));

    // R2
    capture_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_zero || cap_full) |=> !cal_valid);

    // R4
    gated_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> $past(cal_valid));

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> $past(raw_valid, 2));

    // R10
    mode_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bipolar != $past(bipolar)) |=> !cal_valid);
endmodule

bind calcorr_top calcorr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_valid  (raw_valid),
    .cap_zero   (cap_zero),
    .cap_full   (cap_full),
    .bipolar    (bipolar),
    .code_valid (code_valid),
    .cal_valid  (cal_valid)
);

// File: tb/sim_calcorr_top.sv
// Directed bench for the offset and gain correction unit.
module sim_calcorr_top;
    localparam int RAW_W = 24;
    localparam int Q     = RAW_W + 20;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    raw_valid = 1'b0;
    logic signed [RAW_W-1:0] raw_data = '0;
    logic                    cap_zero = 1'b0;
    logic                    cap_full = 1'b0;
    logic                    bipolar = 1'b0;
    logic                    code_valid;
    logic [19:0]             code;
    logic                    cal_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    calcorr_top #(.RAW_W(RAW_W)) u0 (
        .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_data(raw_data),
        .cap_zero(cap_zero), .cap_full(cap_full), .bipolar(bipolar),
        .code_valid(code_valid), .code(code), .cal_valid(cal_valid)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference code from the requirement formulas (R6, R7, R8, R9).
    function automatic logic [19:0] ref_code(input longint raw, input longint z,
                                             input longint f, input bit bip);
        logic signed [127:0] s, k, d, p, t;
        s = 128'(f - z);
        k = (128'sd1 <<< Q) / s;
        d = 128'(raw - z);
        p = d * k;
        if (!bip) t = (p + (128'sd1 <<< (Q-21))) >>> (Q-20);
        else      t = ((p + (128'sd1 <<< (Q-20))) >>> (Q-19)) + 128'sd524288;
        if (t < 0)                  return 20'h00000;
        else if (t > 128'sd1048575) return 20'hFFFFF;
        else                        return t[19:0];
    endfunction

    // Run a calibration and report how many clocks cal_valid took.
    task automatic calibrate(input longint z, input longint f, output int waited);
        @(negedge clk); raw_data = RAW_W'(z); cap_zero = 1'b1;
        @(negedge clk); cap_zero = 1'b0; raw_data = RAW_W'(f); cap_full = 1'b1;
        @(negedge clk); cap_full = 1'b0; raw_data = '0;
        waited = 1;
        while (!cal_valid && waited < Q + 20) begin
            @(negedge clk); waited++;
        end
    endtask

    // One conversion, checked two clocks later.
    task automatic convert(input longint raw, input logic [19:0] exp, input string req);
        @(negedge clk); raw_valid = 1'b1; raw_data = RAW_W'(raw);
        @(negedge clk); raw_valid = 1'b0;
        @(negedge clk);
        chk(code_valid === 1'b1, {req, " valid"}, longint'(code_valid), 1);
        chk(code === exp, req, longint'(code), longint'(exp));
    endtask

    // A conversion request that must produce nothing.
    task automatic convert_blocked(input string req);
        @(negedge clk); raw_valid = 1'b1; raw_data = 24'sd1234;
        @(negedge clk); raw_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(code_valid === 1'b0, req, longint'(code_valid), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cal_valid === 1'b0, "R1 cal_valid", longint'(cal_valid), 0);
        chk(code_valid === 1'b0, "R1 code_valid", longint'(code_valid), 0);
        chk(code === 20'h0, "R1 code", longint'(code), 0);
    endtask

    task automatic t_uncal();
        convert_blocked("R4 uncalibrated");
    endtask

    task automatic t_uni_steps();
        int w;
        calibrate(1000, 1000 + (1 << 21), w);
        chk(w <= Q + 4, "R2 cal time", w, Q + 4);
        chk(cal_valid === 1'b1, "R2 cal_valid", longint'(cal_valid), 1);
        convert(1000, 20'h00000, "R7 zero point");
        convert(1001, 20'h00001, "R7 half step rounds up");
        convert(1002, 20'h00001, "R7 one step");
        convert(1003, 20'h00002, "R7 1.5 steps");
        convert(1000 + (1 << 21) - 3, 20'hFFFFF, "R7 last transition");
        convert(1000 + (1 << 21) - 4, 20'hFFFFE, "R7 below last transition");
    endtask

    task automatic t_uni_general();
        int w;
        longint z = -50000, f = 1234567;
        calibrate(z, f, w);
        chk(cal_valid === 1'b1, "R2 general cal", longint'(cal_valid), 1);
        convert(0, ref_code(0, z, f, 0), "R6 R7 mid");
        convert(777777, ref_code(777777, z, f, 0), "R6 R7 upper");
        convert(-49999, ref_code(-49999, z, f, 0), "R7 near zero");
        convert(1234566, ref_code(1234566, z, f, 0), "R7 near full");
        convert(1300000, 20'hFFFFF, "R9 above full");
        convert(-60000, 20'h00000, "R9 below zero");
    endtask

    task automatic t_stream();
        longint z = -50000, f = 1234567;
        longint vals [5] = '{-50000, 12345, 400000, 999999, -3};
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk(code_valid === 1'b1, "R5 stream valid", longint'(code_valid), 1);
                chk(code === ref_code(vals[i-2], z, f, 0), "R5 stream code",
                    longint'(code), longint'(ref_code(vals[i-2], z, f, 0)));
            end else begin
                chk(code_valid === 1'b0, "R5 stream lead", longint'(code_valid), 0);
            end
            raw_valid = (i < 5);
            raw_data  = (i < 5) ? RAW_W'(vals[i]) : '0;
        end
        @(negedge clk);
        chk(code_valid === 1'b0, "R5 stream end", longint'(code_valid), 0);
    endtask

    task automatic t_mode_change();
        @(negedge clk); bipolar = 1'b1;
        @(negedge clk);
        chk(cal_valid === 1'b0, "R10 mode flip clears", longint'(cal_valid), 1'b0);
        convert_blocked("R10 codes blocked");
    endtask

    task automatic t_bipolar();
        int w;
        longint z = 100, f = 100 + (1 << 21);
        calibrate(z, f, w);
        chk(cal_valid === 1'b1, "R2 bipolar cal", longint'(cal_valid), 1);
        convert(100, 20'h80000, "R8 midscale");
        convert(96, 20'h7FFFF, "R8 one step below");
        convert(102, 20'h80001, "R8 half step up");
        convert(98, 20'h80000, "R8 half step below");
        convert(100 - (1 << 21), 20'h00000, "R8 negative full");
        convert(100 - (1 << 21) - 500, 20'h00000, "R9 below negative full");
        convert(100 + (1 << 21) + 500, 20'hFFFFF, "R9 above full bipolar");
        convert(-300001, ref_code(-300001, z, f, 1), "R8 general");
    endtask

    task automatic t_bad_span();
        int w;
        calibrate(5000, 5000, w);
        chk(cal_valid === 1'b0, "R3 zero span", longint'(cal_valid), 0);
        calibrate(5000, 4000, w);
        chk(cal_valid === 1'b0, "R3 negative span", longint'(cal_valid), 0);
        convert_blocked("R3 no code");
    endtask

    task automatic t_zero_clears();
        int w;
        calibrate(0, 1 << 20, w);
        chk(cal_valid === 1'b1, "R2 recal", longint'(cal_valid), 1);
        @(negedge clk); cap_zero = 1'b1; raw_data = '0;
        @(negedge clk); cap_zero = 1'b0;
        chk(cal_valid === 1'b0, "R2 zero capture clears", longint'(cal_valid), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_uncal();
        t_uni_steps();
        t_uni_general();
        t_stream();
        t_mode_change();
        t_bipolar();
        t_bad_span();
        t_zero_clears();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule